// File: doc/BRIEF.md
# Eight-bit Arithmetic/Logic Unit with Registered Condition Flags

This block is the arithmetic/logic datapath of a small eight-bit processor. Each cycle it takes an operation code and two operands, `opa` and `opb`. One clock edge later it presents the result together with a flag byte. The flag byte carries carry, zero, sign and overflow. A second byte, a write-enable mask, tells the caller which of those flags the operation defines. The caller merges the flag byte into its own status register under that mask, so flags that an operation does not define stay unchanged.

Subtraction is formed as `opa + ~opb + 1`. Carry therefore means "no borrow" and is set exactly when `opa >= opb` as unsigned values. The single-bit shifts report the bit pushed out in carry and report any flip of the sign bit in overflow. Compare uses subtract and bit-test uses AND; for both, the caller discards the result. The move operation passes `opb` through, so that loads and register copies update zero and sign.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `result`=0, `flag_val`=0 and `flag_mask`=0.
- R2: Outputs change only at a rising edge, and they reflect the inputs sampled at that edge (one cycle of latency).
- R3: Op 1 (add) gives `result`=(opa+opb) mod 256. Carry is the unsigned carry out and overflow is two's-complement overflow. The mask is 0xF0.
- R4: Op 2 (subtract) gives `result`=(opa+~opb+1) mod 256. Carry=1 exactly when opa>=opb (unsigned), and overflow is set when the signed difference lies outside -128..127. The mask is 0xF0.
- R5: Whenever zero (bit 6) is in the mask, it equals (result==0). Whenever sign (bit 5) is in the mask, it equals result bit 7.
- R6: Op 0 (move) gives `result`=opb. Ops 3, 4 and 5 give opa AND, OR and XOR opb. All four use mask 0x60.
- R7: Op 6 (rotate) rotates opa right by opb[2:0] places, so amounts 0 and 8 leave it unchanged. The mask is 0x60, which leaves carry and overflow untouched.
- R8: Op 7 (left shift) gives opa<<1 with 0 shifted in. Carry is opa bit 7 and overflow is (result bit 7 XOR opa bit 7). The mask is 0xF0.
- R9: Op 8 (right shift) gives opa>>1 with 0 shifted in. Carry is opa bit 0 and overflow is (result bit 7 XOR opa bit 7). The mask is 0xF0.
- R10: The flag byte is laid out with C at bit 7, Z at bit 6, S at bit 5 and V at bit 4. Bit 3, the halt position, and bits 2..0 are always 0 in both bytes. Any `flag_val` bit outside the mask is 0.
- R11: Op codes 9 to 15 give `result`=0, `flag_val`=0 and `flag_mask`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| opa | input | 8 | First operand (destination value) |
| opb | input | 8 | Second operand (source value, immediate or rotate amount) |
| result | output | 8 | Registered result |
| flag_val | output | 8 | Registered flag values, C Z S V at bits 7..4 |
| flag_mask | output | 8 | Registered flag write enables, same layout |

## Verification
Every result, flag and mask is due exactly one rising edge after its operands are presented. The bench therefore drives inputs on the falling edge and compares the outputs on the following falling edge against a behavioural model of the previous operation. One nanosecond after each new drive, the bench also confirms that the outputs have not yet moved, which checks the latency rule. A reset raised in mid-run is expected to clear the outputs at the next edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned FB_C = 7;
  localparam int unsigned FB_Z = 6;
  localparam int unsigned FB_S = 5;
  localparam int unsigned FB_V = 4;
  localparam int unsigned FB_H = 3;

  localparam logic [FLAG_W-1:0] MASK_ALL = 8'hF0;
  localparam logic [FLAG_W-1:0] MASK_ZS  = 8'h60;

  typedef enum logic [3:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_ROR  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_PASS = 2'd0,
    LG_AND  = 2'd1,
    LG_OR   = 2'd2,
    LG_XOR  = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = full[W-1:0];
    cout  = full[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned W   = 8,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   rot,
  output logic [W-1:0]   shl,
  output logic [W-1:0]   shr,
  output logic           shl_out,
  output logic           shr_out
);
  logic [2*W-1:0] doubled;

  always_comb begin
    doubled = {a, a} >> amt;
    rot     = doubled[W-1:0];
    shl     = {a[W-2:0], 1'b0};
    shr     = {1'b0, a[W-1:1]};
    shl_out = a[W-1];
    shr_out = a[0];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op,
  input  logic [W-1:0]      opa,
  input  logic [W-1:0]      opb,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flag_val,
  output logic [FLAG_W-1:0] flag_mask
);
  logic [W-1:0] add_sum, logic_y, rot_y, shl_y, shr_y;
  logic         add_c, add_v, shl_c, shr_c;
  logic         is_sub;
  logic_sel_e   lsel;

  logic [W-1:0]      nxt_res;
  logic              nxt_c, nxt_v;
  logic [FLAG_W-1:0] nxt_mask, nxt_raw;

  assign is_sub = (op == OP_SUB);

  alu8_adder #(.W(W)) u_add (
    .a(opa), .b(opb), .sub(is_sub),
    .sum(add_sum), .cout(add_c), .ovf(add_v)
  );

  always_comb begin
    case (op)
      OP_AND:  lsel = LG_AND;
      OP_OR:   lsel = LG_OR;
      OP_XOR:  lsel = LG_XOR;
      default: lsel = LG_PASS;
    endcase
  end

  alu8_logic #(.W(W)) u_logic (
    .a(opa), .b(opb), .sel(lsel), .y(logic_y)
  );

  alu8_shift #(.W(W), .SHW(SHW)) u_shift (
    .a(opa), .amt(opb[SHW-1:0]),
    .rot(rot_y), .shl(shl_y), .shr(shr_y),
    .shl_out(shl_c), .shr_out(shr_c)
  );

  always_comb begin
    nxt_res  = '0;
    nxt_c    = 1'b0;
    nxt_v    = 1'b0;
    nxt_mask = '0;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt_res  = add_sum;
        nxt_c    = add_c;
        nxt_v    = add_v;
        nxt_mask = MASK_ALL;
      end
      OP_PASS, OP_AND, OP_OR, OP_XOR: begin
        nxt_res  = logic_y;
        nxt_mask = MASK_ZS;
      end
      OP_ROR: begin
        nxt_res  = rot_y;
        nxt_mask = MASK_ZS;
      end
      OP_SHL: begin
        nxt_res  = shl_y;
        nxt_c    = shl_c;
        nxt_v    = shl_y[W-1] ^ opa[W-1];
        nxt_mask = MASK_ALL;
      end
      OP_SHR: begin
        nxt_res  = shr_y;
        nxt_c    = shr_c;
        nxt_v    = shr_y[W-1] ^ opa[W-1];
        nxt_mask = MASK_ALL;
      end
      default: ;
    endcase
    nxt_raw       = '0;
    nxt_raw[FB_C] = nxt_c;
    nxt_raw[FB_Z] = (nxt_res == '0);
    nxt_raw[FB_S] = nxt_res[W-1];
    nxt_raw[FB_V] = nxt_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flag_val  <= '0;
      flag_mask <= '0;
    end else begin
      result    <= nxt_res;
      flag_val  <= nxt_raw & nxt_mask;
      flag_mask <= nxt_mask;
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && flag_val == '0 && flag_mask == '0));

  p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |=> ({flag_val[FB_C], result} == ({1'b0, $past(opa)} + {1'b0, $past(opb)})));

  p_sub_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |=> (flag_val[FB_C] == ($past(opa) >= $past(opb))));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
    flag_mask[FB_Z] |-> (flag_val[FB_Z] == (result == '0)));

  p_sign_flag_r5: assert property (@(posedge clk) disable iff (rst)
    flag_mask[FB_S] |-> (flag_val[FB_S] == result[W-1]));

  p_ror_keeps_cv_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ROR) |=> (!flag_mask[FB_C] && !flag_mask[FB_V]));

  p_shl_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHL) |=> (flag_val[FB_C] == $past(opa[W-1])));

  p_shr_carry_r9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHR) |=> (flag_val[FB_C] == $past(opa[0])));

  p_low_bits_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_val[FB_H:0] == '0 && flag_mask[FB_H:0] == '0));

  p_val_in_mask_r10: assert property (@(posedge clk) disable iff (rst)
    ((flag_val & ~flag_mask) == '0));

  p_undefined_op_r11: assert property (@(posedge clk) disable iff (rst)
    (op > OP_SHR) |=> (result == '0 && flag_mask == '0));
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op  = 4'd0;
  logic [7:0] opa = 8'd0;
  logic [7:0] opb = 8'd0;
  logic [7:0] result, flag_val, flag_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int    e_res, e_flg, e_msk;
  string e_tag;

  always #2.5 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .op(op), .opa(opa), .opb(opb),
    .result(result), .flag_val(flag_val), .flag_mask(flag_mask)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int o);
    case (o)
      1: return "R3";
      2: return "R4";
      0, 3, 4, 5: return "R6";
      6: return "R7";
      7: return "R8";
      8: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model(int o, int a, int b);
    int r, c, v, s, m, k;
    r = 0; c = 0; v = 0; m = 0;
    case (o)
      0: begin r = b; m = 'h60; end
      1: begin s = a + b; r = s % 256; c = (s > 255); v = (((a ^ r) & (b ^ r) & 128) != 0); m = 'hF0; end
      2: begin s = a + (255 - b) + 1; r = s % 256; c = (a >= b); v = (((a ^ b) & (a ^ r) & 128) != 0); m = 'hF0; end
      3: begin r = a & b; m = 'h60; end
      4: begin r = a | b; m = 'h60; end
      5: begin r = a ^ b; m = 'h60; end
      6: begin k = b % 8; r = ((a >> k) | (a << (8 - k))) % 256; m = 'h60; end
      7: begin r = (a * 2) % 256; c = a / 128; v = (((a ^ r) & 128) != 0); m = 'hF0; end
      8: begin r = a / 2; c = a % 2; v = (((a ^ r) & 128) != 0); m = 'hF0; end
      default: ;
    endcase
    e_res = r;
    e_msk = m;
    e_flg = ((c << 7) | ((r == 0) << 6) | ((r / 128) << 5) | (v << 4)) & m;
    e_tag = tag_of(o);
  endtask

  task automatic compare();
    chk(e_tag, "result", int'(result), e_res);
    chk(e_tag, "mask", int'(flag_mask), e_msk);
    chk(e_tag, "C/V flags", int'(flag_val & 8'h90), e_flg & 'h90);
    chk("R5", "Z/S flags", int'(flag_val & 8'h60), e_flg & 'h60);
    chk("R10", "low flag bits", int'({flag_val[3:0], flag_mask[3:0]}), 0);
  endtask

  task automatic step(int o, int a, int b);
    logic [7:0] hr, hf, hm;
    compare();
    hr = result; hf = flag_val; hm = flag_mask;
    op = 4'(o); opa = 8'(a); opb = 8'(b);
    model(o, a, b);
    #1;
    chk("R2", "held before edge", int'({hr, hf, hm}), int'({result, flag_val, flag_mask}));
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1", "reset result", int'(result), 0);
    chk("R1", "reset flags", int'(flag_val), 0);
    chk("R1", "reset mask", int'(flag_mask), 0);
    rst = 1'b0;
    e_res = 0; e_flg = 0; e_msk = 0; e_tag = "R1";
    step(1, 'h7F, 'h01);
    step(1, 'hFF, 'h01);
    step(1, 'h80, 'h80);
    step(2, 5, 5);
    step(2, 3, 5);
    step(2, 'h80, 1);
    step(2, 'h7F, 'hFF);
    step(0, 0, 0);
    step(0, 0, 'h9C);
    step(3, 'hF0, 'h0F);
    step(4, 'h00, 'h81);
    step(5, 'hAA, 'hAA);
    step(6, 'h81, 0);
    step(6, 'h81, 8);
    step(6, 'h81, 1);
    step(6, 'h02, 9);
    step(7, 'h80, 0);
    step(7, 'h40, 0);
    step(7, 'h01, 0);
    step(8, 'h01, 0);
    step(8, 'h81, 0);
    step(8, 'h02, 0);
    for (int o = 9; o < 16; o++) step(o, 'h55, 'hAA);
    for (int i = 0; i < 400; i++) step(int'($urandom % 16), int'($urandom % 256), int'($urandom % 256));
    compare();
    rst = 1'b1;
    op = 4'd1; opa = 8'hFF; opb = 8'h01;
    @(negedge clk);
    chk("R1", "mid-run reset", int'({result, flag_val, flag_mask}), 0);
    rst = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule